// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers fourteen interrupt sources and presents the most urgent pending, enabled request to a processor core. Seven sources come from pins. Six of these are general request pins, and each one can be set to react to a rising edge or to a falling edge. The seventh is a power-monitor pin that reacts only to a falling edge. The other seven sources are single-cycle pulses from inside the chip: three serial channels and four timers. Every pin passes through a two-flop synchronizer. A detected edge or pulse sets a sticky request flag. The core acknowledges the presented vector to claim it, and that acknowledge clears the flag.

The block keeps a hardware stack of the sources now in service. A request can interrupt a running service routine only if its priority is strictly higher than the routine being served. A return strobe pops one level and resumes the level below it. A wake output tells a halted core that some enabled request is pending. Source index 0 is the most urgent and index 13 the least, so the vector number is also the priority rank.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous reset, all request flags are 0, the nesting depth is 0, and `irq_req_o`, `wake_o` and `svc_src_o` are 0.
- R2: For general pin n (`ext_pin_i[n+1]`, n = 0..5), `ext_rise_i[n]`=1 selects rising edges and 0 selects falling edges. An edge of the other polarity sets nothing. A pin change made before clock edge k sets flag `pend_o[n+1]` at clock edge k+2.
- R3: The power-monitor pin `ext_pin_i[0]` sets flag `pend_o[0]` on a falling edge only. A rising edge never sets it.
- R4: A one-cycle high on `int_req_i[j]` sets flag `pend_o[7+j]` at that clock edge. Bits 0..2 are serial channels 0..2 and bits 3..6 are timers 0..3.
- R5: A flag is recorded even when its `src_en_i` bit is 0. A disabled flag is never presented, cannot be acknowledged, and does not drive `wake_o`.
- R6: Among enabled pending flags, the lowest index wins, and `irq_vec_o` carries that index. Hold is 0, INT0..INT5 are 1..6, serial0..2 are 7..9 and timer0..3 are 10..13.
- R7: `ack_i` while `irq_req_o`=1 clears the flag of `irq_vec_o`, pushes that index, and makes it `svc_src_o` with the depth one higher. If a new edge or pulse for the same source arrives in that cycle, the flag stays set.
- R8: While the depth is nonzero, a request is presented only if its index is strictly lower than `svc_src_o`. Requests of equal or lower priority stay pending.
- R9: `reti_i` lowers the depth by one and restores the previous `svc_src_o`. It is ignored at depth 0. If `ack_i` and `reti_i` are high in the same cycle, only the return takes effect.
- R10: When the depth equals `NEST_DEPTH`, `irq_req_o` is 0 until a return.
- R11: `wake_o` is 1 whenever any enabled flag is pending, whatever the nesting state.
- R12: Pin edges are masked for the first three cycles after reset. A pin that is held at the active level through reset does not raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 7 | Bit 0 is the power-monitor pin; bits 1..6 are general pins INT0..INT5 |
| ext_rise_i | input | 6 | Edge polarity per general pin (1 = rising) |
| int_req_i | input | 7 | Internal pulses: serial0..2 on bits 0..2, timer0..3 on bits 3..6 |
| src_en_i | input | 14 | Enable per source index |
| ack_i | input | 1 | Core claims the presented vector |
| reti_i | input | 1 | Core returns from the current service level |
| pend_o | output | 14 | Sticky request flags by source index |
| irq_req_o | output | 1 | A request is presented to the core |
| irq_vec_o | output | 4 | Index of the presented source |
| wake_o | output | 1 | Enabled request pending; leaves halt |
| depth_o | output | clog2(NEST_DEPTH+1) | Number of levels in service |
| svc_src_o | output | 4 | Source currently in service (0 when idle) |

## Verification
Several properties are checked on every cycle. A presented vector always points at an enabled pending flag. A preempting vector always outranks the level in service, and no request is presented while the stack is full. An acknowledge always pushes exactly one level and a return pops exactly one. The depth never goes past its bound, and a flag set in the same cycle as its clear survives. Other behaviours can only be shown by the bench scenarios: the priority order across every pair of sources, the edge polarity and timing of each pin, the masking after reset, and the restore order through a fourteen-level chain. The bench also runs a second copy with a four-deep stack so that the full-stack block can be reached.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned N_SRC  = 14;
    localparam int unsigned N_PIN  = 7;
    localparam int unsigned N_POL  = N_PIN - 1;
    localparam int unsigned N_INTL = N_SRC - N_PIN;
    localparam int unsigned VEC_W  = $clog2(N_SRC);

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [N_SRC-1:0] srcvec_t;

    typedef struct packed {
        logic hit;
        vec_t idx;
    } pick_t;

    // lowest set index wins: index order is priority order
    function automatic pick_t pick_highest(srcvec_t req);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                p.hit = 1'b1;
                p.idx = vec_t'(i);
            end
        end
        return p;
    endfunction

    function automatic srcvec_t vec_to_mask(vec_t v);
        return srcvec_t'(1) << v;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] rise_i,
    output logic [WIDTH-1:0] edge_o
);

    localparam logic [1:0] ARM_DONE = 2'd3;

    logic [1:0] arm_q;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst)
            arm_q <= '0;
        else if (arm_q != ARM_DONE)
            arm_q <= arm_q + 2'd1;
    end

    assign armed = (arm_q == ARM_DONE);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic s1_q, s2_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_i[g];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign edge_o[g] = armed & (rise_i[g] ? (s2_q & ~prev_q) : (~s2_q & prev_q));

        // R2
        no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
            edge_o[g] |=> (!edge_o[g] || ($past(rise_i[g]) != rise_i[g])));
    end

endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t set_i,
    input  srcvec_t clr_i,
    output srcvec_t pend_o
);

    srcvec_t flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign pend_o = flag_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_i & clr_i) != '0) |=> ((pend_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  logic               pop_i,
    input  vec_t               push_val_i,
    output logic [DEPTH_W-1:0] depth_o,
    output vec_t               top_o,
    output logic               full_o,
    output logic               empty_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(DEPTH);

    vec_t               stk_q [DEPTH];
    logic [DEPTH_W-1:0] depth_q;
    logic               do_pop, do_push;

    assign empty_o = (depth_q == '0);
    assign full_o  = (depth_q == DEPTH_MAX);
    assign do_pop  = pop_i & ~empty_o;
    assign do_push = push_i & ~pop_i & ~full_o;

    always_ff @(posedge clk) begin
        if (rst)
            depth_q <= '0;
        else if (do_pop)
            depth_q <= depth_q - 1'b1;
        else if (do_push)
            depth_q <= depth_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push)
            stk_q[PTR_W'(depth_q)] <= push_val_i;
    end

    assign depth_o = depth_q;
    assign top_o   = empty_o ? vec_t'(0) : stk_q[PTR_W'(depth_q - 1'b1)];

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth_q <= DEPTH_MAX);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NEST_DEPTH = 16,
    parameter int unsigned DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [6:0]         ext_pin_i,
    input  logic [5:0]         ext_rise_i,
    input  logic [6:0]         int_req_i,
    input  logic [13:0]        src_en_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic [13:0]        pend_o,
    output logic               irq_req_o,
    output logic [3:0]         irq_vec_o,
    output logic               wake_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic [3:0]         svc_src_o
);

    logic [N_PIN-1:0] pin_pol;
    logic [N_PIN-1:0] pin_edge;
    srcvec_t          set_vec, clr_vec, pend, live;
    pick_t            win;
    vec_t             svc_top;
    logic             st_full, st_empty;
    logic             can_preempt, take_ack;

    // power-monitor pin is fixed to falling edges
    assign pin_pol = {ext_rise_i, 1'b0};

    irq_edge_det #(.WIDTH(N_PIN)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_pin_i),
        .rise_i (pin_pol),
        .edge_o (pin_edge)
    );

    assign set_vec = {int_req_i, pin_edge};

    irq_pend_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    assign live        = pend & src_en_i;
    assign win         = pick_highest(live);
    assign can_preempt = st_empty | (win.idx < svc_top);
    assign irq_req_o   = win.hit & can_preempt & ~st_full;
    assign irq_vec_o   = win.idx;
    assign take_ack    = ack_i & irq_req_o & ~reti_i;
    assign clr_vec     = take_ack ? vec_to_mask(win.idx) : '0;
    assign wake_o      = |live;
    assign pend_o      = pend;

    irq_nest_stack #(.DEPTH(NEST_DEPTH), .DEPTH_W(DEPTH_W)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (take_ack),
        .pop_i      (reti_i),
        .push_val_i (win.idx),
        .depth_o    (depth_o),
        .top_o      (svc_top),
        .full_o     (st_full),
        .empty_o    (st_empty)
    );

    assign svc_src_o = svc_top;

    // R6
    vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (pend_o[irq_vec_o] && src_en_i[irq_vec_o]));

    // R8
    preempt_strict_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && depth_o != '0) |-> (irq_vec_o < svc_src_o));

    // R10
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_o == DEPTH_W'(NEST_DEPTH)) |-> !irq_req_o);

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_req_o && !reti_i) |=>
            (depth_o == $past(depth_o) + 1'b1) && (svc_src_o == $past(irq_vec_o)));

    // R9
    reti_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (reti_i && depth_o != '0) |=> (depth_o == $past(depth_o) - 1'b1));

    // R11
    wake_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> wake_o);

endmodule

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ext_pin = 7'b0000001;
    logic [5:0]  rise_sel = 6'b111111;
    logic [6:0]  int_pulse = '0;
    logic [13:0] en = '1;
    logic        ack = 1'b0, reti = 1'b0;

    logic [13:0] pend, pend_s;
    logic        req, req_s, wake, wake_s;
    logic [3:0]  vec, vec_s, svc, svc_s;
    logic [4:0]  depth;
    logic [2:0]  depth_s;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .ext_rise_i(rise_sel),
        .int_req_i(int_pulse), .src_en_i(en), .ack_i(ack), .reti_i(reti),
        .pend_o(pend), .irq_req_o(req), .irq_vec_o(vec), .wake_o(wake),
        .depth_o(depth), .svc_src_o(svc)
    );

    irq_nest_ctrl #(.NEST_DEPTH(4)) i_irq_nest_ctrl_shallow (
        .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .ext_rise_i(rise_sel),
        .int_req_i(int_pulse), .src_en_i(en), .ack_i(ack), .reti_i(reti),
        .pend_o(pend_s), .irq_req_o(req_s), .irq_vec_o(vec_s), .wake_o(wake_s),
        .depth_o(depth_s), .svc_src_o(svc_s)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; ack = 1'b0; reti = 1'b0; int_pulse = '0;
        ext_pin = 7'b0000001; rise_sel = '1; en = '1;
        cyc(3);
        rst = 1'b0;
        cyc(4);
    endtask

    // fire the active edge of source k, then restore the idle level
    task automatic raise(input int k);
        if (k == 0) begin
            ext_pin[0] = 1'b0; cyc(4); ext_pin[0] = 1'b1; cyc(4);
        end else if (k < 7) begin
            ext_pin[k] = 1'b1; cyc(4); ext_pin[k] = 1'b0; cyc(4);
        end else begin
            int_pulse[k-7] = 1'b1; cyc(1); int_pulse = '0; cyc(1);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; cyc(1); reti = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 / R12: INT0 held at its active level through reset
        ext_pin = 7'b0000011;
        cyc(3);
        rst = 1'b0;
        cyc(5);
        check("R12 no request from level held at reset", int'(pend), 0);
        ext_pin[1] = 1'b0;
        cyc(4);
        check("R1 flags after reset", int'(pend), 0);
        check("R1 depth after reset", int'(depth), 0);
        check("R1 req after reset", int'(req), 0);
        check("R1 wake after reset", int'(wake), 0);
        check("R1 svc after reset", int'(svc), 0);

        // R2 exact latency
        ext_pin[1] = 1'b1;
        cyc(2);
        check("R2 flag not yet set", int'(pend[1]), 0);
        cyc(1);
        check("R2 flag set third edge", int'(pend[1]), 1);
        ext_pin[1] = 1'b0; cyc(4);
        do_ack();
        check("R7 flag cleared by ack", int'(pend), 0);
        check("R7 depth one", int'(depth), 1);
        check("R7 svc is INT0", int'(svc), 1);
        do_reti();
        check("R9 depth back to zero", int'(depth), 0);

        // R2 falling polarity on each general pin
        for (int j = 0; j < 6; j++) begin
            rise_sel[j] = 1'b0;
            ext_pin[j+1] = 1'b1; cyc(4);
            check("R2 rising ignored when falling selected", int'(pend[j+1]), 0);
            ext_pin[j+1] = 1'b0; cyc(4);
            check("R2 falling detected", int'(pend[j+1]), 1);
            do_ack(); do_reti();
            rise_sel[j] = 1'b1;
        end

        // R3 power-monitor pin, falling only
        rise_sel = '1;
        ext_pin[0] = 1'b0; cyc(4);
        check("R3 hold falling sets flag", int'(pend[0]), 1);
        do_ack(); do_reti();
        ext_pin[0] = 1'b1; cyc(4);
        check("R3 hold rising ignored", int'(pend[0]), 0);

        // R4 internal pulses
        for (int j = 0; j < 7; j++) begin
            int_pulse[j] = 1'b1; cyc(1); int_pulse = '0;
            check("R4 pulse sets flag next edge", int'(pend[7+j]), 1);
            check("R4 R6 vector of internal source", int'(vec), 7 + j);
            do_ack(); do_reti();
        end

        // R6 R7 R9 single-source sweep
        for (int k = 0; k < 14; k++) begin
            raise(k);
            check("R6 single request presented", int'(req), 1);
            check("R6 single vector", int'(vec), k);
            do_ack();
            check("R7 flags clear", int'(pend), 0);
            check("R7 svc source", int'(svc), k);
            do_reti();
            check("R9 depth zero after return", int'(depth), 0);
        end

        // R6 R8 R11 all ordered pairs
        for (int a = 0; a < 14; a++) begin
            for (int b = 0; b < 14; b++) begin
                if (a != b) begin
                    raise(a); raise(b);
                    check("R6 pair winner", int'(vec), (a < b) ? a : b);
                    do_ack();
                    check("R8 lower pending does not preempt", int'(req), 0);
                    check("R11 wake with pending while busy", int'(wake), 1);
                    do_reti();
                    check("R6 pair loser next", int'(vec), (a < b) ? b : a);
                    do_ack(); do_reti();
                end
            end
        end

        // R5 enable gating
        en = '0;
        raise(3);
        check("R5 flag recorded while disabled", int'(pend[3]), 1);
        check("R5 no request while disabled", int'(req), 0);
        check("R5 no wake while disabled", int'(wake), 0);
        do_ack();
        check("R5 ack ignored while disabled", int'(depth), 0);
        check("R5 flag kept after ignored ack", int'(pend[3]), 1);
        en = '1;
        cyc(1);
        check("R5 enabled request vector", int'(vec), 3);
        do_ack(); do_reti();

        // R8 same priority waits, higher preempts; R9 restore
        raise(5); do_ack();
        raise(5);
        check("R8 same priority stays pending", int'(pend[5]), 1);
        check("R8 same priority not presented", int'(req), 0);
        raise(4);
        check("R8 higher presented", int'(vec), 4);
        do_ack();
        check("R8 nested depth", int'(depth), 2);
        do_reti();
        check("R9 restored svc", int'(svc), 5);
        check("R9 restored depth", int'(depth), 1);
        do_reti();
        check("R8 waiting request after return", int'(vec), 5);
        do_ack(); do_reti();

        // R7 new pulse same cycle as its ack
        raise(10);
        ack = 1'b1; int_pulse[3] = 1'b1; cyc(1); ack = 1'b0; int_pulse = '0;
        check("R7 set wins over clear", int'(pend[10]), 1);
        check("R7 depth after ack", int'(depth), 1);
        do_reti(); do_ack(); do_reti();

        // R9 ack with return, return at depth zero
        raise(8);
        ack = 1'b1; reti = 1'b1; cyc(1); ack = 1'b0; reti = 1'b0;
        check("R9 ack ignored with return", int'(depth), 0);
        check("R9 flag kept", int'(pend[8]), 1);
        do_ack(); do_reti();

        // R8 R10 full nesting chain
        for (int k = 13; k >= 0; k--) begin
            raise(k);
            check("R8 chain preempt vector", int'(vec), k);
            do_ack();
            check("R8 chain depth", int'(depth), 14 - k);
        end
        check("R8 chain top svc", int'(svc), 0);
        check("R10 shallow depth capped", int'(depth_s), 4);
        check("R10 shallow blocked when full", int'(req_s), 0);
        check("R10 shallow svc", int'(svc_s), 10);
        check("R11 shallow wake while full", int'(wake_s), 1);
        do_reti();
        check("R10 shallow preempts after return", int'(req_s), 1);
        for (int k = 1; k < 14; k++) begin
            check("R9 chain unwind svc", int'(svc), k);
            do_reti();
        end
        check("R9 chain unwound", int'(depth), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule